// File: doc/BRIEF.md
# Double-Buffered Converter Code and Range Register Interface

This block sits between a parallel 16-bit host bus and a current-output converter core. It keeps a conversion code and an output-range (span) code, each in two stages. A front stage takes host writes. A back stage holds the values the converter core uses. The host picks between code and range with a select line, writes with an active-low strobe, and commits both front-stage values together with an active-high commit strobe. The span code shares the three lowest bus lines with the conversion code. Because a single access carries only one of the two, the lines never conflict.

All host strobes are asynchronous to the system clock. Each passes through a two-flop synchroniser and is then treated as a level or an edge on the clock. The block also provides:
- readback of either stage;
- a clear input that returns the output to the zero-volt code of the active range while keeping the range;
- reset values that depend on whether the range is programmable or fixed by pins;
- a one-cycle pulse that marks the start of the deglitch interval after a commit.

Top module: `dac_dbuf_if`

## Requirements
- R1: With `sel_span` low and `wr_n` low, the front code register loads `bus_in[13:0]`. The back code register does not change until a commit.
- R2: With `sel_span` high and `wr_n` low, the front range register loads `bus_in[2:0]`. The range codes are:
  - 000 = 0..5 V and 001 = 0..10 V (unipolar);
  - 010 = ±5 V, 011 = ±10 V and 100 = ±2.5 V (bipolar);
  - 101 = -2.5..7.5 V (offset).
  
  The unused codes 110 and 111 are stored as 000.
- R3: While `commit` is high, both front registers are copied into the back registers (`dac_code`, `dac_span`) together. When `commit` is low and clear is inactive, the back registers hold their values. Repeating a commit with no write in between changes nothing.
- R4: Holding `wr_n` low and `commit` high makes both stages transparent. `dac_code` then follows `bus_in` one clock after the bus changes, and `glitch_start` stays low.
- R5: A rising edge of `commit` while `wr_n` is high produces `glitch_start` high for exactly one clock cycle. This pulse appears after the third rising clock edge following the edge on the pin.
- R6: While `clr_n` is low, both code registers load the zero-volt code of the active range and both range registers keep their values. The zero-volt codes are:
  - 0x0000 for 000 and 001;
  - 0x2000 for 010, 011 and 100;
  - 0x1000 for 101.
  
  Clear takes priority over writes and commits.
- R7: After `rst` in programmable mode (`pin_span_en` low), both range registers hold 000 and both code registers hold 0. `bus_oe` and `glitch_start` are low.
- R8: With `pin_span_en` high, `dac_span` equals the normalised `span_pins`, and range writes have no effect. Reset and clear load the zero-volt code of the pin range.
- R9: While `rd` is high, `bus_oe` is 1. `commit` high selects the back stage and `commit` low selects the front stage. `sel_span` high returns the range in `bus_out[2:0]`, and `sel_span` low returns the code in `bus_out[13:0]`. All other bits are zero.
- R10: With `pin_span_en` high, a range read leaves `bus_oe` at 0.
- R11: While `rd` is low, `bus_oe` is 0.
- R12: Strobes driven together from one toggling signal (`wr_n` tied to `commit`) behave as an edge-triggered pair. The front code register captures in the low phase, and the back register takes that value when the signal goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on initialisation) |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| commit | input | 1 | Active-high commit strobe and stage select for reads, asynchronous |
| rd | input | 1 | Active-high read strobe, asynchronous |
| clr_n | input | 1 | Active-low clear, asynchronous |
| sel_span | input | 1 | 0 selects code, 1 selects range |
| bus_in | input | 16 | Host bus write data |
| pin_span_en | input | 1 | 1 takes the range from `span_pins` |
| span_pins | input | 3 | Fixed range code |
| bus_out | output | 16 | Read data |
| bus_oe | output | 1 | Read data enable (tristate control) |
| dac_code | output | 14 | Back-stage conversion code |
| dac_span | output | 3 | Active range code |
| glitch_start | output | 1 | One-cycle deglitch start pulse |

## Verification
Every strobe passes through two synchroniser flops and then one register, so its effect on `dac_code`, `dac_span`, `bus_out` and `bus_oe` is due after the third rising edge. The bench therefore changes inputs on falling edges, waits four rising edges, and samples on the next falling edge. `glitch_start` is checked exactly on the falling edge after the third rising edge and again one cycle later. In flow-through mode, bus changes are not synchronised, so the result is sampled one full cycle after each bus change.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef logic [2:0] span_t;

  typedef enum logic [1:0] {
    ZP_ZERO    = 2'd0,
    ZP_HALF    = 2'd1,
    ZP_QUARTER = 2'd2
  } zero_pt_e;

  // Unused range codes fall back to the 0..5 V range.
  function automatic span_t span_norm(input span_t s);
    return (s > 3'd5) ? 3'd0 : s;
  endfunction

  // Which fraction of full scale produces zero volts in a range.
  function automatic zero_pt_e zero_point(input span_t s);
    case (s)
      3'd2, 3'd3, 3'd4: return ZP_HALF;
      3'd5:             return ZP_QUARTER;
      default:          return ZP_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{IDLE[b]}};
      else     chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/dbuf_regs.sv
module dbuf_regs
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_span_en,
  input  span_t             span_pins,
  input  logic              wr_act,
  input  logic              upd_act,
  input  logic              clr_act,
  input  logic              sel_span,
  input  logic [DATA_W-1:0] bus_code,
  input  span_t             bus_span,
  output logic [DATA_W-1:0] in_code_q,
  output span_t             in_span_q,
  output logic [DATA_W-1:0] dac_code_q,
  output span_t             dac_span_eff
);
  localparam logic [DATA_W-1:0] HALF    = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] QUARTER = DATA_W'(1) << (DATA_W - 2);

  span_t             dac_span_q;
  span_t             pin_span;
  logic [DATA_W-1:0] zero_code;
  logic [DATA_W-1:0] in_code_n, dac_code_n;
  span_t             in_span_n, dac_span_n;

  function automatic logic [DATA_W-1:0] zp_code(input span_t s);
    case (zero_point(s))
      ZP_HALF:    return HALF;
      ZP_QUARTER: return QUARTER;
      default:    return '0;
    endcase
  endfunction

  assign pin_span     = span_norm(span_pins);
  assign dac_span_eff = pin_span_en ? pin_span : dac_span_q;
  assign zero_code    = zp_code(dac_span_eff);

  always_comb begin
    in_code_n  = in_code_q;
    in_span_n  = in_span_q;
    dac_code_n = dac_code_q;
    dac_span_n = dac_span_q;
    if (clr_act) begin
      in_code_n  = zero_code;
      dac_code_n = zero_code;
    end else begin
      if (wr_act) begin
        if (!sel_span)         in_code_n = bus_code;
        else if (!pin_span_en) in_span_n = span_norm(bus_span);
      end
      if (upd_act) begin
        dac_code_n = in_code_n;
        dac_span_n = in_span_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_span_q  <= '0;
      dac_span_q <= '0;
      in_code_q  <= pin_span_en ? zp_code(pin_span) : '0;
      dac_code_q <= pin_span_en ? zp_code(pin_span) : '0;
    end else begin
      in_code_q  <= in_code_n;
      in_span_q  <= in_span_n;
      dac_code_q <= dac_code_n;
      dac_span_q <= dac_span_n;
    end
  end

  p_span_kept_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> $stable(dac_span_q) && $stable(in_span_q));
  p_zero_on_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_act && $stable(dac_span_eff) |=> dac_code_q == zp_code(dac_span_eff));
  p_back_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd_act && !clr_act |=> $stable(dac_code_q) && $stable(dac_span_q));
  p_pin_span_r8: assert property (@(posedge clk) disable iff (rst)
    pin_span_en |-> dac_span_eff == span_norm(span_pins));
endmodule

// File: rtl/dbuf_readback.sv
module dbuf_readback
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_act,
  input  logic              stage_sel,
  input  logic              sel_span,
  input  logic              pin_span_en,
  input  logic [DATA_W-1:0] in_code,
  input  span_t             in_span,
  input  logic [DATA_W-1:0] dac_code,
  input  span_t             dac_span,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe
);
  logic [BUS_W-1:0] word;
  logic             allow;

  always_comb begin
    if (sel_span) word = BUS_W'(stage_sel ? dac_span : in_span);
    else          word = BUS_W'(stage_sel ? dac_code : in_code);
    allow = rd_act && !(sel_span && pin_span_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      bus_out <= allow ? word : '0;
      bus_oe  <= allow;
    end
  end

  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> !bus_oe);
  p_no_pin_span_read_r10: assert property (@(posedge clk) disable iff (rst)
    pin_span_en && sel_span |=> !bus_oe);
endmodule

// File: rtl/dac_dbuf_if.sv
module dac_dbuf_if
  import dbuf_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              commit,
  input  logic              rd,
  input  logic              clr_n,
  input  logic              sel_span,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              pin_span_en,
  input  logic [2:0]        span_pins,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] dac_code,
  output logic [2:0]        dac_span,
  output logic              glitch_start
);
  localparam int SPAN_W = $bits(span_t);
  localparam int NSYNC  = 5;
  // bit order: sel_span, clr_n, rd, commit, wr_n
  localparam logic [NSYNC-1:0] IDLE = 5'b01001;

  logic [NSYNC-1:0]  raw, synced;
  logic              wr_s, upd_s, rd_s, clr_s, sel_s;
  logic              upd_prev;
  logic [DATA_W-1:0] in_code;
  span_t             in_span;

  assign raw = {sel_span, clr_n, rd, commit, wr_n};

  dbuf_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst(rst), .async_in(raw), .sync_out(synced)
  );

  assign wr_s  = !synced[0];
  assign upd_s = synced[1];
  assign rd_s  = synced[2];
  assign clr_s = !synced[3];
  assign sel_s = synced[4];

  dbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .pin_span_en(pin_span_en), .span_pins(span_pins),
    .wr_act(wr_s), .upd_act(upd_s), .clr_act(clr_s), .sel_span(sel_s),
    .bus_code(bus_in[DATA_W-1:0]), .bus_span(bus_in[SPAN_W-1:0]),
    .in_code_q(in_code), .in_span_q(in_span),
    .dac_code_q(dac_code), .dac_span_eff(dac_span)
  );

  dbuf_readback #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_rb (
    .clk(clk), .rst(rst), .rd_act(rd_s), .stage_sel(upd_s), .sel_span(sel_s),
    .pin_span_en(pin_span_en), .in_code(in_code), .in_span(in_span),
    .dac_code(dac_code), .dac_span(dac_span),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_prev     <= 1'b0;
      glitch_start <= 1'b0;
    end else begin
      upd_prev     <= upd_s;
      glitch_start <= upd_s && !upd_prev && !wr_s;
    end
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    glitch_start |=> !glitch_start);
  p_no_pulse_flow_r4: assert property (@(posedge clk) disable iff (rst)
    wr_s |=> !glitch_start);
  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(glitch_start) |-> $past(upd_s) && !$past(upd_prev));
endmodule

// File: tb/dac_dbuf_if_test.sv
module dac_dbuf_if_test;
  logic        clk = 0, rst = 1;
  logic        wr_n = 1, commit = 0, rd = 0, clr_n = 1, sel_span = 0;
  logic [15:0] bus_in = '0;
  logic        pin_span_en = 0;
  logic [2:0]  span_pins = '0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [13:0] dac_code;
  logic [2:0]  dac_span;
  logic        glitch_start;

  int n_chk = 0, n_bad = 0;
  logic [13:0] m_in_code, m_dac_code;
  logic [2:0]  m_in_span, m_dac_span;

  always #5 clk = ~clk;

  dac_dbuf_if uut (.*);

  function automatic logic [2:0] nrm(input logic [2:0] s);
    return (s > 3'd5) ? 3'd0 : s;
  endfunction
  function automatic logic [13:0] zc(input logic [2:0] s);
    case (s)
      3'd2, 3'd3, 3'd4: return 14'h2000;
      3'd5:             return 14'h1000;
      default:          return 14'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_back(input string tag);
    chk(dac_code == m_dac_code, tag, dac_code, m_dac_code);
    chk(dac_span == m_dac_span, tag, dac_span, m_dac_span);
  endtask

  task automatic do_write(input bit sp, input logic [15:0] v);
    sel_span = sp; bus_in = v; wr_n = 0;
    settle();
    wr_n = 1;
    settle();
    if (!sp) m_in_code = v[13:0];
    else if (!pin_span_en) m_in_span = nrm(v[2:0]);
    check_back(sp ? "R2 back unchanged after range write" : "R1 back unchanged after code write");
  endtask

  task automatic do_commit();
    commit = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(glitch_start == 1, "R5 pulse due", glitch_start, 1);
    @(negedge clk);
    chk(glitch_start == 0, "R5 pulse one cycle", glitch_start, 0);
    m_dac_code = m_in_code;
    if (!pin_span_en) m_dac_span = m_in_span;
    check_back("R3 commit copies both");
    commit = 0;
    settle();
  endtask

  task automatic do_read(input bit sp, input bit stage);
    logic [15:0] exp;
    bit eoe;
    sel_span = sp; commit = stage; rd = 1;
    if (stage) begin
      m_dac_code = m_in_code;
      if (!pin_span_en) m_dac_span = m_in_span;
    end
    settle();
    eoe = !(sp && pin_span_en);
    if (sp) exp = {13'd0, stage ? m_dac_span : m_in_span};
    else    exp = {2'd0, stage ? m_dac_code : m_in_code};
    chk(bus_oe == eoe, sp && pin_span_en ? "R10 range read off" : "R9 oe", bus_oe, eoe);
    if (eoe) chk(bus_out == exp, "R9 read data", bus_out, exp);
    rd = 0; commit = 0;
    settle();
    chk(bus_oe == 0, "R11 oe low idle", bus_oe, 0);
  endtask

  task automatic do_clear();
    clr_n = 0;
    settle();
    m_in_code = zc(m_dac_span);
    m_dac_code = zc(m_dac_span);
    check_back("R6 clear to zero-volt code");
    clr_n = 1;
    settle();
  endtask

  task automatic do_reset(input bit pin, input logic [2:0] p);
    pin_span_en = pin; span_pins = p;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_in_span = 0;
    m_dac_span = pin ? nrm(p) : 3'd0;
    m_in_code = pin ? zc(nrm(p)) : 14'd0;
    m_dac_code = m_in_code;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4177));
    do_reset(0, 3'd0);
    check_back("R7 reset values");
    chk(bus_oe == 0 && glitch_start == 0, "R7 reset oe/pulse", {bus_oe, glitch_start}, 0);

    do_write(0, 16'h1abc);
    do_write(1, 16'h0003);
    do_commit();
    do_read(0, 0);
    do_read(1, 1);
    do_commit();
    do_write(1, 16'hfff7);
    do_read(1, 0);
    do_commit();
    chk(dac_span == 3'd0, "R2 unused code as 000", dac_span, 0);

    do_write(1, 16'h0005); do_commit(); do_clear();
    do_write(1, 16'h0002); do_commit(); do_clear();
    do_write(0, 16'h0123); do_commit(); do_write(1, 16'h0000); do_commit(); do_clear();

    // R4: flow-through
    sel_span = 0; bus_in = 16'h0555; wr_n = 0; commit = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(glitch_start == 0, "R4 no pulse", glitch_start, 0);
    end
    chk(dac_code == 14'h0555, "R4 transparent", dac_code, 14'h0555);
    bus_in = 16'h2aaa;
    @(negedge clk); @(negedge clk);
    chk(dac_code == 14'h2aaa, "R4 follows bus", dac_code, 14'h2aaa);
    wr_n = 1; commit = 0;
    m_in_code = 14'h2aaa; m_dac_code = 14'h2aaa;
    settle();

    // R12: tied strobes
    bus_in = 16'h0777;
    wr_n = 0; commit = 0; settle();
    check_back("R12 low phase holds back");
    wr_n = 1; commit = 1; settle();
    chk(dac_code == 14'h0777, "R12 rising copies", dac_code, 14'h0777);
    m_in_code = 14'h0777; m_dac_code = 14'h0777;
    bus_in = 16'h0111;
    wr_n = 0; commit = 0; settle();
    wr_n = 1; commit = 1; settle();
    chk(dac_code == 14'h0111, "R12 second edge", dac_code, 14'h0111);
    m_in_code = 14'h0111; m_dac_code = 14'h0111;
    commit = 0; settle();

    // random mix
    for (int k = 0; k < 120; k++) begin
      case ($urandom_range(0, 4))
        0: do_write(0, 16'($urandom));
        1: do_write(1, 16'($urandom_range(0, 7)));
        2: do_commit();
        3: do_read($urandom_range(0, 1), $urandom_range(0, 1));
        default: do_clear();
      endcase
    end

    // R8/R10: pin range
    do_reset(1, 3'd2);
    check_back("R8 reset pin range");
    do_write(1, 16'h0003);
    do_commit();
    chk(dac_span == 3'd2, "R8 range write ignored", dac_span, 2);
    do_read(1, 0);
    do_read(0, 1);
    do_write(0, 16'h0fff); do_commit(); do_clear();
    do_reset(1, 3'd5);
    check_back("R8 reset offset range");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule